// File: doc/BRIEF.md
# Video Line Packet Scheduler

This block decides which packets a serial display host transmits on each video line when the link runs in non-burst mode with sync-end events. Software programs twelve sequence words and an eight-entry length table through a plain register write port. The timing generator then starts each line with a one-cycle pulse. The pulse carries a two-bit line kind and an active-line flag. The scheduler answers with an ordered series of packet descriptors on a valid/ready port. Each descriptor gives the data type, the payload byte count and a payload class. When the line is over, the block raises a one-cycle done pulse, and raises a low-power request with it when the line's words ask for one.

The sequence words come in six pairs, and each pair has a first word and a second word. Each word holds three packet slots. A slot names a length-table index rather than a byte count, so one programmed length (back porch, active width, sync width) is shared by every line type that uses it. After reset the registers hold a working default profile, so a line can be scheduled without any writes. Header assembly, error codes, checksums, lane striping and the physical layer sit downstream.

The control path is a three-state machine. IDLE waits for a line start. SEND presents one descriptor and holds it until it is accepted. FIN issues the done pulse, and the low-power request when it is due. The transitions are:
- IDLE to SEND on a start whose pair has at least one enabled slot.
- IDLE to FIN on a start whose pair has no enabled slot.
- SEND to SEND on acceptance while a later enabled slot remains.
- SEND to FIN on acceptance of the last enabled slot.
- FIN to IDLE unconditionally.

Top module: `vid_line_pkt_sched`

## Requirements
- R1: Register writes (`cfg_we` high) use these addresses:
  - Addresses 0 to 11 hold the sequence words. Address 2p is the first word of pair p and address 2p+1 is its second word.
  - Addresses 12 to 15 hold the length table. Address 12+k carries entry 2k in bits 15:0 and entry 2k+1 in bits 31:16.
  - Writes to addresses 16 and above change nothing.
- R2: Slot s (s = 0, 1, 2) of a sequence word keeps its length index in bits 10s+2:10s, its 6-bit data type in bits 10s+8:10s+3 and its enable in bit 10s+9. Bit 30 of the word is the low-power flag.
- R3: The line kind selects the pair:
  - Kind 0 selects pair 0 and kind 1 selects pair 1.
  - Kind 2 selects pair 2, or pair 3 when `line_active` is high.
  - Kind 3 selects pair 4, or pair 5 when `line_active` is high.
  - A start is accepted only in IDLE and is ignored at any other time.
- R4: A line sends the enabled slots in this order: slots 0, 1, 2 of the first word, then slots 0, 1, 2 of the second word. Disabled slots are skipped. A pair with no enabled slot sends no packet.
- R5: `pkt_len` is the length-table entry named by the slot's length index.
- R6: The first descriptor is valid in the cycle after the start is accepted. A descriptor, and `pkt_valid` with it, stays unchanged until the cycle in which `pkt_ready` is high.
- R7: `line_done` is a one-cycle pulse with no descriptor valid beside it. It comes in the cycle after the last descriptor is accepted, or in the cycle after the start for an empty pair. `lp_req` is high exactly with that pulse, and only when bit 30 of either word of the pair is set.
- R8: `pkt_payload` is 2 for data type 0x3E. For any other type whose low nibble is 9 or more it is 1. For every other type it is 0.
- R9: A line uses the words and lengths that held when its start was accepted. Writes made in that same cycle or later affect only later lines.
- R10: After reset the length table is zero except entries 6 and 7, which are 0x0F. The sequence words hold this profile (blank = 0x19, slots listed in slot order):
  - Pair 0 first word: 0x01/idx0, blank/idx1, 0x31/idx0, with the low-power flag set.
  - Pair 1 first word: the same with 0x11 in place of 0x01.
  - Pairs 2 and 4 first word: the same with 0x21 in place of 0x01.
  - Pairs 3 and 5 first word: 0x21/idx0, blank/idx1, 0x31/idx0, with the flag clear.
  - Pairs 3 and 5 second word: blank/idx2, 0x3E/idx3, blank/idx4.
  - All other words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register write address |
| cfg_wdata | input | 32 | Register write data |
| line_start | input | 1 | One-cycle line start pulse |
| line_kind | input | 2 | Line kind (sync start, sync end, horizontal group A or B) |
| line_active | input | 1 | Line carries active pixels |
| pkt_ready | input | 1 | Downstream accepts the current descriptor |
| pkt_valid | output | 1 | Descriptor valid |
| pkt_dtype | output | 6 | Packet data type |
| pkt_len | output | 16 | Payload byte count |
| pkt_payload | output | 2 | 0 short, 1 blanking fill, 2 pixel data |
| line_done | output | 1 | Line finished pulse |
| lp_req | output | 1 | Low-power request after the line |

## Verification
The properties assume only two things of the environment. `pkt_ready` may rise or fall in any cycle. `line_start` may arrive at any time, including while a line is still running. The properties also assume that the kind and active inputs matter only in the start cycle.

The stimulus drives every input on the falling edge, so each value is settled long before the sampling edge. It uses three acceptance patterns: always ready, alternating and pseudo-random. It issues starts in the middle of a line, writes in the same cycle as a start and during a line, and writes to addresses outside the map. A behavioural queue model predicts every cycle of the valid, descriptor, done and low-power outputs.

// File: rtl/vlps_pkg.sv
package vlps_pkg;

    localparam int SLOTS_PER_WORD = 3;
    localparam int SEQ_PAIRS      = 6;
    localparam int SEQ_WORDS      = 2 * SEQ_PAIRS;
    localparam int SEQ_W          = 31;
    localparam int SEQ_IDX_W      = $clog2(SEQ_WORDS);
    localparam int LEN_ENTRIES    = 8;
    localparam int LEN_W          = 16;
    localparam int LEN_WORDS      = LEN_ENTRIES / 2;
    localparam int LEN_WORD_IDX_W = $clog2(LEN_WORDS);
    localparam int LIDX_W         = $clog2(LEN_ENTRIES);
    localparam int DT_W           = 6;
    localparam int SLOT_STRIDE    = 10;
    localparam int DT_OFS         = 3;
    localparam int EN_OFS         = 9;
    localparam int LP_BIT         = 30;
    localparam int LINE_SLOTS     = 2 * SLOTS_PER_WORD;
    localparam int SLOT_IDX_W     = $clog2(LINE_SLOTS);

    localparam logic [DT_W-1:0] DT_VSYNC_BEG = 6'h01;
    localparam logic [DT_W-1:0] DT_VSYNC_FIN = 6'h11;
    localparam logic [DT_W-1:0] DT_HSYNC_BEG = 6'h21;
    localparam logic [DT_W-1:0] DT_HSYNC_FIN = 6'h31;
    localparam logic [DT_W-1:0] DT_BLANK     = 6'h19;
    localparam logic [DT_W-1:0] DT_PIX24     = 6'h3E;

    typedef enum logic [1:0] {
        PAY_NONE  = 2'd0,
        PAY_FILL  = 2'd1,
        PAY_PIXEL = 2'd2
    } pay_e;

    function automatic logic [SEQ_W-1:0] slot_bits(input int s,
                                                   input logic [DT_W-1:0] dt,
                                                   input logic [LIDX_W-1:0] li);
        logic [SEQ_W-1:0] w;
        w = '0;
        w[SLOT_STRIDE*s +: LIDX_W]        = li;
        w[SLOT_STRIDE*s + DT_OFS +: DT_W] = dt;
        w[SLOT_STRIDE*s + EN_OFS]         = 1'b1;
        return w;
    endfunction

    function automatic logic [SEQ_W-1:0] sync_word(input logic [DT_W-1:0] first,
                                                   input logic lp);
        logic [SEQ_W-1:0] w;
        w = slot_bits(0, first, 3'd0) | slot_bits(1, DT_BLANK, 3'd1)
          | slot_bits(2, DT_HSYNC_FIN, 3'd0);
        w[LP_BIT] = lp;
        return w;
    endfunction

    // Reset profile of the sequence words (word index = 2*pair + second)
    function automatic logic [SEQ_W-1:0] default_word(input int idx);
        logic [SEQ_W-1:0] w;
        unique case (idx)
            0:       w = sync_word(DT_VSYNC_BEG, 1'b1);
            2:       w = sync_word(DT_VSYNC_FIN, 1'b1);
            4, 8:    w = sync_word(DT_HSYNC_BEG, 1'b1);
            6, 10:   w = sync_word(DT_HSYNC_BEG, 1'b0);
            7, 11:   w = slot_bits(0, DT_BLANK, 3'd2) | slot_bits(1, DT_PIX24, 3'd3)
                       | slot_bits(2, DT_BLANK, 3'd4);
            default: w = '0;
        endcase
        return w;
    endfunction

    function automatic logic [LEN_W-1:0] default_len(input int entry);
        return (entry >= LEN_ENTRIES - 2) ? LEN_W'(16'h000F) : '0;
    endfunction

    function automatic pay_e classify(input logic [DT_W-1:0] dt);
        if (dt == DT_PIX24)       return PAY_PIXEL;
        else if (dt[3:0] >= 4'h9) return PAY_FILL;
        else                      return PAY_NONE;
    endfunction

endpackage

// File: rtl/vlps_cfg_regs.sv
module vlps_cfg_regs
    import vlps_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [SEQ_W-1:0]  seq_q [SEQ_WORDS],
    output logic [LEN_W-1:0]  len_q [LEN_ENTRIES]
);

    localparam int LEN_BASE = SEQ_WORDS;

    logic [2*LEN_W-1:0] lenw_q [LEN_WORDS];
    logic [ADDR_W-1:0]  len_off;
    logic               hit_seq;
    logic               hit_len;

    assign len_off = wr_addr - ADDR_W'(LEN_BASE);
    assign hit_seq = wr_en && (wr_addr < ADDR_W'(SEQ_WORDS));
    assign hit_len = wr_en && !hit_seq && (wr_addr < ADDR_W'(LEN_BASE + LEN_WORDS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEQ_WORDS; i++) seq_q[i] <= default_word(i);
            for (int k = 0; k < LEN_WORDS; k++)
                lenw_q[k] <= {default_len(2*k+1), default_len(2*k)};
        end else if (hit_seq) begin
            seq_q[wr_addr[SEQ_IDX_W-1:0]] <= wr_data[SEQ_W-1:0];
        end else if (hit_len) begin
            lenw_q[len_off[LEN_WORD_IDX_W-1:0]] <= wr_data;
        end
    end

    for (genvar k = 0; k < LEN_WORDS; k++) begin : g_len_split
        assign len_q[2*k]   = lenw_q[k][LEN_W-1:0];
        assign len_q[2*k+1] = lenw_q[k][2*LEN_W-1:LEN_W];
    end

endmodule

// File: rtl/vlps_slot_pick.sv
module vlps_slot_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0]         mask,
    input  logic [$clog2(N):0]   from,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);

    localparam int IW = $clog2(N);

    // Lowest enabled slot at or above "from"
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vid_line_pkt_sched.sv
module vid_line_pkt_sched
    import vlps_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              line_start,
    input  logic [1:0]        line_kind,
    input  logic              line_active,
    input  logic              pkt_ready,
    output logic              pkt_valid,
    output logic [5:0]        pkt_dtype,
    output logic [15:0]       pkt_len,
    output logic [1:0]        pkt_payload,
    output logic              line_done,
    output logic              lp_req
);

    localparam int IW = SLOT_IDX_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_FIN
    } state_e;

    state_e state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    logic [SEQ_W-1:0] seq_q [SEQ_WORDS];
    logic [LEN_W-1:0] len_q [LEN_ENTRIES];

    logic [SEQ_W-1:0] lo_q, hi_q;
    logic [LEN_W-1:0] len_cap [LEN_ENTRIES];
    logic             lp_q;

    logic [2:0]       pair_sel;
    logic [SEQ_W-1:0] live_lo, live_hi;
    logic             first_found, next_found;
    logic [IW-1:0]    first_idx, next_idx;
    logic             take;

    function automatic logic [LINE_SLOTS-1:0] en_mask(input logic [SEQ_W-1:0] lo,
                                                      input logic [SEQ_W-1:0] hi);
        logic [LINE_SLOTS-1:0] m;
        for (int s = 0; s < SLOTS_PER_WORD; s++) begin
            m[s]                  = lo[SLOT_STRIDE*s + EN_OFS];
            m[SLOTS_PER_WORD + s] = hi[SLOT_STRIDE*s + EN_OFS];
        end
        return m;
    endfunction

    vlps_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .seq_q   (seq_q),
        .len_q   (len_q)
    );

    // Line kind to pair: kinds 0/1 direct, kinds 2/3 pick a pair by the active flag
    always_comb begin
        if (line_kind < 2'd2) pair_sel = {1'b0, line_kind};
        else                  pair_sel = {line_kind, 1'b0} - 3'd2 + {2'b00, line_active};
    end

    assign live_lo = seq_q[{pair_sel, 1'b0}];
    assign live_hi = seq_q[{pair_sel, 1'b1}];
    assign take    = (state_q == ST_IDLE) && line_start;

    vlps_slot_pick #(.N(LINE_SLOTS)) u_pick_first (
        .mask  (en_mask(live_lo, live_hi)),
        .from  ('0),
        .found (first_found),
        .idx   (first_idx)
    );

    vlps_slot_pick #(.N(LINE_SLOTS)) u_pick_next (
        .mask  (en_mask(lo_q, hi_q)),
        .from  ({1'b0, idx_q} + (IW+1)'(1)),
        .found (next_found),
        .idx   (next_idx)
    );

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: if (line_start) begin
                state_d = first_found ? ST_SEND : ST_FIN;
                idx_d   = first_idx;
            end
            ST_SEND: if (pkt_ready) begin
                state_d = next_found ? ST_SEND : ST_FIN;
                idx_d   = next_idx;
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Snapshot of the selected pair and the length table at line start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            lp_q <= 1'b0;
            for (int e = 0; e < LEN_ENTRIES; e++) len_cap[e] <= '0;
        end else if (take) begin
            lo_q <= live_lo;
            hi_q <= live_hi;
            lp_q <= live_lo[LP_BIT] | live_hi[LP_BIT];
            for (int e = 0; e < LEN_ENTRIES; e++) len_cap[e] <= len_q[e];
        end
    end

    logic [SEQ_W-1:0]  cur_word;
    logic [IW-1:0]     cur_sub;
    logic [DT_W-1:0]   cur_dt;
    logic [LIDX_W-1:0] cur_li;

    always_comb begin
        if (idx_q < IW'(SLOTS_PER_WORD)) begin
            cur_word = lo_q;
            cur_sub  = idx_q;
        end else begin
            cur_word = hi_q;
            cur_sub  = idx_q - IW'(SLOTS_PER_WORD);
        end
        cur_dt = cur_word[SLOT_STRIDE*int'(cur_sub) + DT_OFS +: DT_W];
        cur_li = cur_word[SLOT_STRIDE*int'(cur_sub) +: LIDX_W];
    end

    always_comb begin
        pkt_valid   = (state_q == ST_SEND);
        pkt_dtype   = cur_dt;
        pkt_len     = len_cap[cur_li];
        pkt_payload = 2'(classify(cur_dt));
        line_done   = (state_q == ST_FIN);
        lp_req      = (state_q == ST_FIN) && lp_q;
    end

endmodule

// File: rtl/vlps_chk.sv
module vlps_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        line_start,
    input logic        pkt_ready,
    input logic        pkt_valid,
    input logic [5:0]  pkt_dtype,
    input logic [15:0] pkt_len,
    input logic [1:0]  pkt_payload,
    input logic        line_done,
    input logic        lp_req
);

    AST_START_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        line_start && !pkt_valid && !line_done |=> pkt_valid || line_done); // R3

    AST_HOLD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dtype) && $stable(pkt_len) && $stable(pkt_payload)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done); // R7

    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !pkt_valid); // R7

    AST_LP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> line_done); // R7

    AST_PIXEL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && (pkt_dtype == 6'h3E) |-> pkt_payload == 2'd2); // R8

    AST_SHORT_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && (pkt_dtype[3:0] < 4'h9) |-> pkt_payload == 2'd0); // R8

endmodule

bind vid_line_pkt_sched vlps_chk u_vlps_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .pkt_ready   (pkt_ready),
    .pkt_valid   (pkt_valid),
    .pkt_dtype   (pkt_dtype),
    .pkt_len     (pkt_len),
    .pkt_payload (pkt_payload),
    .line_done   (line_done),
    .lp_req      (lp_req)
);

// File: tb/vid_line_pkt_sched_bench.sv
module vid_line_pkt_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        line_start = 1'b0;
    logic [1:0]  line_kind = '0;
    logic        line_active = 1'b0;
    logic        pkt_ready = 1'b1;
    logic        pkt_valid;
    logic [5:0]  pkt_dtype;
    logic [15:0] pkt_len;
    logic [1:0]  pkt_payload;
    logic        line_done;
    logic        lp_req;

    always #4 clk = ~clk;

    vid_line_pkt_sched u_vid_line_pkt_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .line_start(line_start), .line_kind(line_kind),
        .line_active(line_active), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
        .pkt_dtype(pkt_dtype), .pkt_len(pkt_len), .pkt_payload(pkt_payload),
        .line_done(line_done), .lp_req(lp_req)
    );

    int  errors = 0;
    int  checks = 0;
    bit  finished = 0;
    int  ready_mode = 0;
    int  lfsr = 32'h1D2C;

    // behavioural model state
    int  mseq [12];
    int  mlen [8];
    int  mstate = 0;
    bit  m_lp = 0;
    int  q_dt [$];
    int  q_len [$];
    int  q_pay [$];

    // observation log of the current line
    int  o_dt [$];
    int  o_len [$];
    int  o_pay [$];
    int  o_lines = 0;
    bit  o_lp = 0;

    function automatic int slot(int s, int dt, int li);
        return (li << (10*s)) | (dt << (10*s + 3)) | (1 << (10*s + 9));
    endfunction

    function automatic int sync3(int dt, int lp);
        return slot(0, dt, 0) | slot(1, 'h19, 1) | slot(2, 'h31, 0) | (lp << 30);
    endfunction

    function automatic void chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    function automatic void model_reset();
        foreach (mseq[i]) mseq[i] = 0;
        mseq[0]  = sync3('h01, 1);
        mseq[2]  = sync3('h11, 1);
        mseq[4]  = sync3('h21, 1);
        mseq[8]  = sync3('h21, 1);
        mseq[6]  = sync3('h21, 0);
        mseq[10] = sync3('h21, 0);
        mseq[7]  = slot(0, 'h19, 2) | slot(1, 'h3E, 3) | slot(2, 'h19, 4);
        mseq[11] = mseq[7];
        foreach (mlen[i]) mlen[i] = 0;
        mlen[6] = 'h0F;
        mlen[7] = 'h0F;
    endfunction

    function automatic void model_build(int kind, int act);
        int pair;
        int w;
        pair = (kind < 2) ? kind : ((kind == 2) ? 2 + act : 4 + act);
        q_dt.delete(); q_len.delete(); q_pay.delete();
        m_lp = ((mseq[2*pair] >> 30) & 1) | ((mseq[2*pair+1] >> 30) & 1);
        for (int h = 0; h < 2; h++) begin
            w = mseq[2*pair + h];
            for (int s = 0; s < 3; s++) begin
                if ((w >> (10*s + 9)) & 1) begin
                    int dt;
                    dt = (w >> (10*s + 3)) & 'h3F;
                    q_dt.push_back(dt);
                    q_len.push_back(mlen[(w >> (10*s)) & 7]);
                    q_pay.push_back(dt == 'h3E ? 2 : (((dt & 'hF) >= 9) ? 1 : 0));
                end
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
            mstate = 0;
            q_dt.delete(); q_len.delete(); q_pay.delete();
        end else begin
            if (pkt_valid && pkt_ready) begin
                o_dt.push_back(int'(pkt_dtype));
                o_len.push_back(int'(pkt_len));
                o_pay.push_back(int'(pkt_payload));
            end
            if (line_done) begin
                o_lines++;
                o_lp = lp_req;
            end
            if (mstate == 1) begin
                if (pkt_ready) begin
                    void'(q_dt.pop_front()); void'(q_len.pop_front()); void'(q_pay.pop_front());
                    if (q_dt.size() == 0) mstate = 2;
                end
            end else if (mstate == 2) begin
                mstate = 0;
            end else if (line_start) begin
                model_build(int'(line_kind), int'(line_active));
                mstate = (q_dt.size() != 0) ? 1 : 2;
            end
            if (cfg_we) begin
                if (cfg_addr < 12) mseq[cfg_addr] = int'(cfg_wdata) & 32'h7FFF_FFFF;
                else if (cfg_addr < 16) begin
                    mlen[2*(cfg_addr-12)]   = int'(cfg_wdata[15:0]);
                    mlen[2*(cfg_addr-12)+1] = int'(cfg_wdata[31:16]);
                end
            end
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(pkt_valid == (mstate == 1), "R6 valid", int'(pkt_valid), int'(mstate == 1));
            if (mstate == 1 && pkt_valid) begin
                chk(int'(pkt_dtype) == q_dt[0], "R4 dtype", int'(pkt_dtype), q_dt[0]);
                chk(int'(pkt_len) == q_len[0], "R5 len", int'(pkt_len), q_len[0]);
                chk(int'(pkt_payload) == q_pay[0], "R8 payload", int'(pkt_payload), q_pay[0]);
            end
            chk(line_done == (mstate == 2), "R7 done", int'(line_done), int'(mstate == 2));
            chk(lp_req == (mstate == 2 && m_lp), "R7 lp", int'(lp_req), int'(mstate == 2 && m_lp));
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (ready_mode == 0) pkt_ready = 1'b1;
            else if (ready_mode == 1) pkt_ready = ~pkt_ready;
            else begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h0000_B400 : 0);
                pkt_ready = lfsr[0];
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_log();
        o_dt.delete(); o_len.delete(); o_pay.delete();
        o_lines = 0; o_lp = 0;
    endtask

    task automatic start(int k, int a);
        @(negedge clk);
        line_start = 1'b1; line_kind = 2'(k); line_active = a[0];
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!line_done && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (n >= 300) chk(0, "R7 line never finished", 0, 1);
        @(posedge clk);
        #1;
    endtask

    task automatic run_line(int k, int a);
        clear_log();
        start(k, a);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!pkt_valid && !line_done && !lp_req, "R10 reset outputs",
            int'({pkt_valid, line_done, lp_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: default profile, vertical sync start line
        run_line(0, 0);
        chk(o_dt.size() == 3, "R10 count", o_dt.size(), 3);
        chk(o_dt[0] == 'h01 && o_dt[2] == 'h31, "R10 order", o_dt[0], 'h01);
        chk(o_lp == 1, "R7 lp default", int'(o_lp), 1);
        chk(o_len[2] == 0, "R10 len table", o_len[2], 0);

        // program lengths
        wr(12, 32'h0030_0000);
        wr(13, 32'h05A0_0060);
        wr(14, 32'h0007_0090);

        run_line(2, 1);
        chk(o_dt.size() == 6, "R3 active line count", o_dt.size(), 6);
        chk(o_dt[4] == 'h3E, "R4 pixel position", o_dt[4], 'h3E);
        chk(o_len[4] == 'h5A0, "R5 active width", o_len[4], 'h5A0);
        chk(o_len[1] == 'h30, "R5 sync width", o_len[1], 'h30);
        chk(o_pay[4] == 2 && o_pay[3] == 1 && o_pay[0] == 0, "R8 classes", o_pay[4], 2);
        chk(o_lp == 0, "R7 no lp on active", int'(o_lp), 0);

        ready_mode = 1;
        run_line(3, 0);
        chk(o_dt.size() == 3 && o_dt[0] == 'h21 && o_lp, "R3 kind3 blank", o_dt.size(), 3);
        run_line(3, 1);
        chk(o_dt.size() == 6, "R3 kind3 active", o_dt.size(), 6);
        run_line(2, 0);
        chk(o_dt.size() == 3, "R3 kind2 blank", o_dt.size(), 3);

        // R2/R4: sparse slots
        wr(2, slot(2, 'h29, 5));
        wr(3, slot(1, 'h08, 7));
        run_line(1, 0);
        chk(o_dt.size() == 2, "R4 skip count", o_dt.size(), 2);
        chk(o_dt[0] == 'h29 && o_len[0] == 7, "R2 slot2 fields", o_dt[0], 'h29);
        chk(o_dt[1] == 'h08 && o_len[1] == 'h0F, "R5 entry7", o_len[1], 'h0F);
        chk(o_pay[0] == 1 && o_pay[1] == 0, "R8 long/short", o_pay[1], 0);
        chk(o_lp == 0, "R7 no lp flag", int'(o_lp), 0);

        // empty pair
        wr(0, 0);
        wr(1, 0);
        run_line(0, 0);
        chk(o_dt.size() == 0 && o_lines == 1, "R4 empty line", o_dt.size(), 0);
        chk(o_lp == 0, "R7 empty no lp", int'(o_lp), 0);
        wr(1, 1 << 30);
        run_line(0, 0);
        chk(o_dt.size() == 0 && o_lp == 1, "R7 lp from second word", int'(o_lp), 1);

        // R1: out-of-map writes ignored, upper length word
        wr(0, slot(0, 'h21, 1));
        wr(16, slot(0, 'h11, 2) | slot(1, 'h19, 3));
        wr(31, 0);
        run_line(0, 0);
        chk(o_dt.size() == 1 && o_dt[0] == 'h21, "R1 addr16 ignored", o_dt[0], 'h21);
        wr(15, 32'h0042_0024);
        wr(0, slot(0, 'h21, 6) | slot(1, 'h19, 7));
        run_line(0, 0);
        chk(o_len[0] == 'h24 && o_len[1] == 'h42, "R1 length halves", o_len[1], 'h42);

        // R9: write during a line affects only the next line
        ready_mode = 2;
        clear_log();
        start(2, 1);
        wr(12, 32'h0077_0000);
        wait_done();
        chk(o_len[1] == 'h30, "R9 snapshot kept", o_len[1], 'h30);
        run_line(2, 1);
        chk(o_len[1] == 'h77, "R9 next line new", o_len[1], 'h77);

        // R9: write in the same cycle as the start
        clear_log();
        @(negedge clk);
        line_start = 1'b1; line_kind = 2'd2; line_active = 1'b1;
        cfg_we = 1'b1; cfg_addr = 5'd12; cfg_wdata = 32'h0055_0000;
        @(negedge clk);
        line_start = 1'b0; cfg_we = 1'b0;
        wait_done();
        chk(o_len[1] == 'h77, "R9 same-cycle write", o_len[1], 'h77);

        // R3: start while busy is ignored
        ready_mode = 0;
        clear_log();
        start(2, 1);
        @(negedge clk);
        line_start = 1'b1; line_kind = 2'd0;
        @(negedge clk);
        line_start = 1'b0;
        wait_done();
        repeat (5) @(negedge clk);
        chk(o_lines == 1 && o_dt.size() == 6, "R3 busy start ignored", o_lines, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule